// File: doc/BRIEF.md
# DDR Bank Timing Tracker

This block follows the state of four DDR SDRAM banks, together with the timers that the bank rules need. In every cycle it reports whether the command on its inputs may go out now. A memory controller places a candidate command on the inputs and reads five legality flags that come straight from the current timer values. It may then commit the command with `cmd_valid`. A committed legal command updates the bank state and reloads the relevant timers. A command presented while it is illegal changes no bank state. It sets an error flag that stays high until reset.

Each bank holds one of four states: idle, row open, open with an automatic precharge pending, or precharging. Per-bank timers cover the activate-to-column delay, the minimum row-active time, the precharge time and write recovery. Shared timers cover the spacing between activates, the write-to-read gap, the read-to-write bus turnaround and the spacing between column commands.

A read with automatic precharge is accepted even when the row-active minimum has not yet elapsed. The internal precharge is then held back until that minimum has passed. The block also reports when a column access is still running, which is the condition under which the clock enable must stay high.

Top module: `ddrbt_tracker`

## Requirements
- R1: After reset every bank is idle, `row_open`, `ap_busy`, `cke_hold` and `proto_err` are 0, and an activate to any bank is reported legal.
- R2: A read or write (op 2 or 3) is legal only to a bank whose row is open with no precharge pending, and only from T_RCD clocks after that bank's activate.
- R3: An activate (op 1) is legal only to an idle bank. It must come at least T_RP clocks after that bank's precharge started, and at least T_RRD clocks after the previous activate to any bank.
- R4: A precharge (op 4) is legal to an open bank once T_RAS has elapsed since its activate and write recovery is complete. To an idle or precharging bank it is legal and does nothing. A precharge-all (op 5) is legal only when every bank passes this test, and it closes every open bank.
- R5: A read with automatic precharge (`cmd_ap` = 1) is accepted before T_RAS has elapsed. Its internal precharge starts on the first edge at least T_RAS clocks after the activate, and the bank becomes idle T_RP clocks later.
- R6: For a write with automatic precharge, the internal precharge starts WR_LAT + BURST_LEN/2 + T_WR clocks after the write.
- R7: A read to any bank is legal only WR_LAT + BURST_LEN/2 + T_WTR clocks after the last write.
- R8: A write is legal only CAS_LAT + BURST_LEN/2 clocks after the last read. Column commands are spaced at least BURST_LEN/2 clocks apart.
- R9: Bit b of `ap_busy` is high from the edge that commits a column command with automatic precharge to bank b until that bank's precharge time ends. Bit b of `row_open` is high while bank b holds an open row, including while its automatic precharge is pending.
- R10: `cke_hold` is high for CAS_LAT + BURST_LEN/2 - 1 clocks after a read, and while any bank's write recovery is still running.
- R11: When `cmd_valid` is high with an illegal command, no bank state changes and `proto_err` goes high and stays high until reset.
- R12: The op code `cmd_op` is encoded as 0 no-op, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all. Codes 0, 6 and 7 are always legal and change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Commit the presented command at this edge |
| cmd_op | input | 3 | Command op code (see R12) |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Automatic precharge with a read or write |
| ok_act | output | 1 | An activate to `cmd_bank` is legal now |
| ok_rd | output | 1 | A read to `cmd_bank` is legal now |
| ok_wr | output | 1 | A write to `cmd_bank` is legal now |
| ok_pre | output | 1 | A precharge to `cmd_bank` is legal now |
| ok_prea | output | 1 | A precharge-all is legal now |
| row_open | output | 4 | Per-bank open-row status, bank 0 at bit 0 |
| ap_busy | output | 4 | Per-bank automatic precharge in progress |
| cke_hold | output | 1 | A column access is running, so the clock enable must stay high |
| proto_err | output | 1 | Sticky flag: an illegal command was presented |

## Verification
The hardest case to reach is the lockout: a read with automatic precharge that is accepted before the row-active minimum has elapsed. The bench has to show that the precharge starts exactly at that minimum, and that the bank is idle again only after the precharge time. The stimulus activates a bank, then issues the read as soon as T_RCD allows. It then polls the legality and `ap_busy` outputs every cycle, so the precharge start shows up as the edge where `row_open` drops. A write with automatic precharge to a second bank, placed so that both internal precharges start on the same edge, covers the case of two banks changing state at once.

// File: rtl/ddrbt_pkg.sv
package ddrbt_pkg;

  localparam logic [2:0] OPC_NOP  = 3'd0;
  localparam logic [2:0] OPC_ACT  = 3'd1;
  localparam logic [2:0] OPC_RD   = 3'd2;
  localparam logic [2:0] OPC_WR   = 3'd3;
  localparam logic [2:0] OPC_PRE  = 3'd4;
  localparam logic [2:0] OPC_PREA = 3'd5;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_OPEN   = 2'd1,
    BK_APWAIT = 2'd2,
    BK_PRECH  = 2'd3
  } bank_st_e;

  // A gap of N clocks is held by a counter loaded with N-1 at the command edge
  function automatic int unsigned gap_load(input int unsigned clocks);
    return (clocks == 0) ? 0 : clocks - 1;
  endfunction

  function automatic int unsigned wr_data_end(input int unsigned wl, input int unsigned bl);
    return wl + bl / 2;
  endfunction

  function automatic int unsigned rd_to_wr(input int unsigned cl, input int unsigned bl);
    return cl + bl / 2;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned maxv);
    int unsigned w;
    w = 1;
    while ((1 << w) <= maxv) w++;
    return w;
  endfunction

endpackage

// File: rtl/ddrbt_gap_timer.sv
module ddrbt_gap_timer #(
  parameter int          CW   = 4,
  parameter int unsigned LOAD = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= CW'(LOAD);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CW'(1);
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/ddrbt_bank.sv
module ddrbt_bank
  import ddrbt_pkg::*;
#(
  parameter int          CW     = 4,
  parameter int unsigned RCD_LD = 2,
  parameter int unsigned RAS_LD = 5,
  parameter int unsigned RP_LD  = 2,
  parameter int unsigned WR_LD  = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     do_act,
  input  logic     do_rd,
  input  logic     do_wr,
  input  logic     do_pre,
  input  logic     ap_flag,
  output bank_st_e st,
  output logic     rcd_ok,
  output logic     ras_ok,
  output logic     rp_ok,
  output logic     wrr_ok,
  output logic     ap_tag,
  output logic     ap_go,
  output logic     prech_go
);
  bank_st_e st_q;
  logic     ap_tag_q;

  assign ap_go    = (st_q == BK_APWAIT) && ras_ok && wrr_ok;
  assign prech_go = ap_go || (do_pre && (st_q == BK_OPEN));

  ddrbt_gap_timer #(.CW(CW), .LOAD(RCD_LD)) u_rcd (
    .clk(clk), .rst_n(rst_n), .load(do_act), .done(rcd_ok));
  ddrbt_gap_timer #(.CW(CW), .LOAD(RAS_LD)) u_ras (
    .clk(clk), .rst_n(rst_n), .load(do_act), .done(ras_ok));
  ddrbt_gap_timer #(.CW(CW), .LOAD(RP_LD)) u_rp (
    .clk(clk), .rst_n(rst_n), .load(prech_go), .done(rp_ok));
  ddrbt_gap_timer #(.CW(CW), .LOAD(WR_LD)) u_wrr (
    .clk(clk), .rst_n(rst_n), .load(do_wr), .done(wrr_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= BK_IDLE;
      ap_tag_q <= 1'b0;
    end else if (do_act) begin
      st_q     <= BK_OPEN;
      ap_tag_q <= 1'b0;
    end else if ((do_rd || do_wr) && ap_flag) begin
      st_q     <= BK_APWAIT;
    end else if (prech_go) begin
      st_q     <= BK_PRECH;
      ap_tag_q <= ap_go;
    end else if ((st_q == BK_PRECH) && rp_ok) begin
      st_q     <= BK_IDLE;
      ap_tag_q <= 1'b0;
    end
  end

  assign st     = st_q;
  assign ap_tag = ap_tag_q;
endmodule

// File: rtl/ddrbt_bus.sv
module ddrbt_bus #(
  parameter int          CW     = 4,
  parameter int unsigned RRD_LD = 1,
  parameter int unsigned WTR_LD = 3,
  parameter int unsigned RTW_LD = 3,
  parameter int unsigned CCD_LD = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic any_act,
  input  logic any_rd,
  input  logic any_wr,
  output logic rrd_ok,
  output logic wtr_ok,
  output logic rtw_ok,
  output logic ccd_ok
);
  logic any_col;
  assign any_col = any_rd || any_wr;

  ddrbt_gap_timer #(.CW(CW), .LOAD(RRD_LD)) u_rrd (
    .clk(clk), .rst_n(rst_n), .load(any_act), .done(rrd_ok));
  ddrbt_gap_timer #(.CW(CW), .LOAD(WTR_LD)) u_wtr (
    .clk(clk), .rst_n(rst_n), .load(any_wr), .done(wtr_ok));
  ddrbt_gap_timer #(.CW(CW), .LOAD(RTW_LD)) u_rtw (
    .clk(clk), .rst_n(rst_n), .load(any_rd), .done(rtw_ok));
  ddrbt_gap_timer #(.CW(CW), .LOAD(CCD_LD)) u_ccd (
    .clk(clk), .rst_n(rst_n), .load(any_col), .done(ccd_ok));
endmodule

// File: rtl/ddrbt_tracker.sv
module ddrbt_tracker
  import ddrbt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2,
  parameter int T_WR      = 2,
  parameter int T_WTR     = 1,
  parameter int CAS_LAT   = 2,
  parameter int WR_LAT    = 1,
  parameter int BURST_LEN = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  input  logic [2:0]            cmd_op,
  input  logic [1:0]            cmd_bank,
  input  logic                  cmd_ap,
  output logic                  ok_act,
  output logic                  ok_rd,
  output logic                  ok_wr,
  output logic                  ok_pre,
  output logic                  ok_prea,
  output logic [NUM_BANKS-1:0]  row_open,
  output logic [NUM_BANKS-1:0]  ap_busy,
  output logic                  cke_hold,
  output logic                  proto_err
);
  localparam int unsigned RCD_LD = gap_load(T_RCD);
  localparam int unsigned RAS_LD = gap_load(T_RAS);
  localparam int unsigned RP_LD  = gap_load(T_RP);
  localparam int unsigned RRD_LD = gap_load(T_RRD);
  localparam int unsigned WR_LD  = gap_load(wr_data_end(WR_LAT, BURST_LEN) + T_WR);
  localparam int unsigned WTR_LD = gap_load(wr_data_end(WR_LAT, BURST_LEN) + T_WTR);
  localparam int unsigned RTW_LD = gap_load(rd_to_wr(CAS_LAT, BURST_LEN));
  localparam int unsigned CCD_LD = gap_load(BURST_LEN / 2);
  localparam int unsigned MAX_LD = max2(max2(max2(RCD_LD, RAS_LD), max2(RP_LD, RRD_LD)),
                                        max2(max2(WR_LD, WTR_LD), max2(RTW_LD, CCD_LD)));
  localparam int CW = cnt_width(MAX_LD);

  // Named internal events, also used by the bound checker
  logic                 cmd_legal;
  logic                 issue;
  logic                 issue_act;
  logic                 issue_rd;
  logic                 issue_wr;
  logic                 issue_col;
  logic [NUM_BANKS-1:0] bank_sel;
  logic [NUM_BANKS-1:0] ap_start;
  logic [NUM_BANKS-1:0] prech_go;

  logic [NUM_BANKS-1:0] act_ok_b, col_ok_b, pre_ok_b, wrr_ok_b;
  logic                 rrd_ok, wtr_ok, rtw_ok, ccd_ok;

  assign bank_sel = NUM_BANKS'(1) << cmd_bank;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_st_e st;
    logic rcd_ok, ras_ok, rp_ok, ap_tag;
    logic do_act, do_rd, do_wr, do_pre;

    assign do_act = issue_act && bank_sel[b];
    assign do_rd  = issue_rd  && bank_sel[b];
    assign do_wr  = issue_wr  && bank_sel[b];
    assign do_pre = issue && (((cmd_op == OPC_PRE) && bank_sel[b]) || (cmd_op == OPC_PREA));

    ddrbt_bank #(
      .CW(CW), .RCD_LD(RCD_LD), .RAS_LD(RAS_LD), .RP_LD(RP_LD), .WR_LD(WR_LD)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .do_act(do_act), .do_rd(do_rd), .do_wr(do_wr), .do_pre(do_pre),
      .ap_flag(cmd_ap),
      .st(st), .rcd_ok(rcd_ok), .ras_ok(ras_ok), .rp_ok(rp_ok),
      .wrr_ok(wrr_ok_b[b]), .ap_tag(ap_tag),
      .ap_go(ap_start[b]), .prech_go(prech_go[b])
    );

    assign act_ok_b[b] = (st == BK_IDLE) || ((st == BK_PRECH) && rp_ok);
    assign col_ok_b[b] = (st == BK_OPEN) && rcd_ok;
    assign pre_ok_b[b] = (st != BK_APWAIT) &&
                         ((st != BK_OPEN) || (ras_ok && wrr_ok_b[b]));
    assign row_open[b] = (st == BK_OPEN) || (st == BK_APWAIT);
    assign ap_busy[b]  = (st == BK_APWAIT) || ((st == BK_PRECH) && ap_tag);
  end

  ddrbt_bus #(
    .CW(CW), .RRD_LD(RRD_LD), .WTR_LD(WTR_LD), .RTW_LD(RTW_LD), .CCD_LD(CCD_LD)
  ) u_bus (
    .clk(clk), .rst_n(rst_n),
    .any_act(issue_act), .any_rd(issue_rd), .any_wr(issue_wr),
    .rrd_ok(rrd_ok), .wtr_ok(wtr_ok), .rtw_ok(rtw_ok), .ccd_ok(ccd_ok)
  );

  assign ok_act  = act_ok_b[cmd_bank] && rrd_ok;
  assign ok_rd   = col_ok_b[cmd_bank] && wtr_ok && ccd_ok;
  assign ok_wr   = col_ok_b[cmd_bank] && rtw_ok && ccd_ok;
  assign ok_pre  = pre_ok_b[cmd_bank];
  assign ok_prea = &pre_ok_b;

  always_comb begin
    case (cmd_op)
      OPC_ACT:  cmd_legal = ok_act;
      OPC_RD:   cmd_legal = ok_rd;
      OPC_WR:   cmd_legal = ok_wr;
      OPC_PRE:  cmd_legal = ok_pre;
      OPC_PREA: cmd_legal = ok_prea;
      default:  cmd_legal = 1'b1;
    endcase
  end

  assign issue     = cmd_valid && cmd_legal;
  assign issue_act = issue && (cmd_op == OPC_ACT);
  assign issue_rd  = issue && (cmd_op == OPC_RD);
  assign issue_wr  = issue && (cmd_op == OPC_WR);
  assign issue_col = issue_rd || issue_wr;

  assign cke_hold = !rtw_ok || !(&wrr_ok_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       proto_err <= 1'b0;
    else if (cmd_valid && !cmd_legal) proto_err <= 1'b1;
  end
endmodule

// File: rtl/ddrbt_tracker_chk.sv
module ddrbt_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RAS     = 6,
  parameter int T_RP      = 3,
  parameter int T_RRD     = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmd_valid,
  input logic                 cmd_legal,
  input logic [1:0]           cmd_bank,
  input logic                 issue_act,
  input logic                 issue_col,
  input logic                 issue_wr,
  input logic                 ok_rd,
  input logic [NUM_BANKS-1:0] ap_start,
  input logic [NUM_BANKS-1:0] prech_go,
  input logic [NUM_BANKS-1:0] row_open,
  input logic                 cke_hold,
  input logic                 proto_err
);
  localparam logic [7:0] RCD8 = 8'(T_RCD);
  localparam logic [7:0] RAS8 = 8'(T_RAS);
  localparam logic [7:0] RP8  = 8'(T_RP);

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R11
  illegal_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_legal && (ap_start == '0)) |=> $stable(row_open));

  // R2
  rd_needs_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_rd |-> row_open[cmd_bank]);

  // R10
  hold_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_wr |=> cke_hold);

  if (T_RRD > 1) begin : g_rrd
    // R3
    rrd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_act |=> !issue_act);
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    logic [7:0] since_act, since_pre;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        since_act <= 8'hFF;
        since_pre <= 8'hFF;
      end else begin
        if (issue_act && (cmd_bank == 2'(b))) since_act <= 8'd1;
        else if (since_act != 8'hFF)           since_act <= since_act + 8'd1;
        if (prech_go[b])                       since_pre <= 8'd1;
        else if (since_pre != 8'hFF)           since_pre <= since_pre + 8'd1;
      end
    end

    // R2
    rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_col && (cmd_bank == 2'(b))) |-> (since_act >= RCD8));

    // R5
    ras_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ap_start[b] |-> (since_act >= RAS8));

    // R3
    rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_act && (cmd_bank == 2'(b))) |-> (since_pre >= RP8));
  end
endmodule

bind ddrbt_tracker ddrbt_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RP(T_RP), .T_RRD(T_RRD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_legal(cmd_legal),
  .cmd_bank(cmd_bank), .issue_act(issue_act), .issue_col(issue_col),
  .issue_wr(issue_wr), .ok_rd(ok_rd), .ap_start(ap_start), .prech_go(prech_go),
  .row_open(row_open), .cke_hold(cke_hold), .proto_err(proto_err)
);

// File: tb/ddrbt_tracker_bench.sv
`timescale 1ns/1ps
module ddrbt_tracker_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_ap = 1'b0;
  logic       ok_act, ok_rd, ok_wr, ok_pre, ok_prea, cke_hold, proto_err;
  logic [3:0] row_open, ap_busy;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ddrbt_tracker u_ddrbt_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .ok_act(ok_act), .ok_rd(ok_rd),
    .ok_wr(ok_wr), .ok_pre(ok_pre), .ok_prea(ok_prea), .row_open(row_open),
    .ap_busy(ap_busy), .cke_hold(cke_hold), .proto_err(proto_err)
  );

  // Defaults: T_RCD 3, T_RAS 6, T_RP 3, T_RRD 2, write data ends 3 clocks after
  // WRITE, recovery 2, T_WTR 1, read-to-write 4, column spacing 2.
  // Fields: op[23:21] bank[20:19] ap[18] {act,rd,wr,pre,prea}[17:13]
  //         row_open[12:9] ap_busy[8:5] cke_hold[4] req[3:0]
  localparam int NV = 25;
  localparam logic [23:0] VEC [NV] = '{
    {3'd1, 2'd0, 1'b0, 5'b10011, 4'b0000, 4'b0000, 1'b0, 4'd3},  // 0  R3 act b0
    {3'd0, 2'd1, 1'b0, 5'b00010, 4'b0001, 4'b0000, 1'b0, 4'd3},  // 1  R3 rrd blocks
    {3'd1, 2'd1, 1'b0, 5'b10010, 4'b0001, 4'b0000, 1'b0, 4'd3},  // 2  R3 act b1
    {3'd2, 2'd0, 1'b0, 5'b01100, 4'b0011, 4'b0000, 1'b0, 4'd2},  // 3  R2 read after rcd
    {3'd0, 2'd0, 1'b0, 5'b00000, 4'b0011, 4'b0000, 1'b1, 4'd8},  // 4  R8 col spacing
    {3'd0, 2'd0, 1'b0, 5'b01000, 4'b0011, 4'b0000, 1'b1, 4'd8},  // 5  R8 turnaround
    {3'd0, 2'd0, 1'b0, 5'b01010, 4'b0011, 4'b0000, 1'b1, 4'd4},  // 6  R4 ras met
    {3'd3, 2'd1, 1'b1, 5'b01100, 4'b0011, 4'b0000, 1'b0, 4'd6},  // 7  R6 write ap b1
    {3'd0, 2'd0, 1'b0, 5'b00010, 4'b0011, 4'b0010, 1'b1, 4'd7},  // 8  R7 wtr blocks
    {3'd0, 2'd1, 1'b0, 5'b00000, 4'b0011, 4'b0010, 1'b1, 4'd9},  // 9  R9 ap pending
    {3'd0, 2'd0, 1'b0, 5'b00110, 4'b0011, 4'b0010, 1'b1, 4'd7},  // 10 R7 wtr blocks
    {3'd2, 2'd0, 1'b1, 5'b01110, 4'b0011, 4'b0010, 1'b1, 4'd4},  // 11 R4 read ap b0
    {3'd0, 2'd1, 1'b0, 5'b00000, 4'b0011, 4'b0011, 1'b1, 4'd6},  // 12 R6 pre starts
    {3'd0, 2'd0, 1'b0, 5'b00011, 4'b0000, 4'b0011, 1'b1, 4'd4},  // 13 R4 prech noop
    {3'd0, 2'd1, 1'b0, 5'b00011, 4'b0000, 4'b0011, 1'b1, 4'd9},  // 14 R9
    {3'd1, 2'd0, 1'b0, 5'b10011, 4'b0000, 4'b0011, 1'b0, 4'd3},  // 15 R3 rp met
    {3'd0, 2'd1, 1'b0, 5'b00010, 4'b0001, 4'b0000, 1'b0, 4'd10}, // 16 R10 hold low
    {3'd0, 2'd0, 1'b0, 5'b00000, 4'b0001, 4'b0000, 1'b0, 4'd2},  // 17 R2 rcd pending
    {3'd2, 2'd0, 1'b1, 5'b01100, 4'b0001, 4'b0000, 1'b0, 4'd5},  // 18 R5 early rd ap
    {3'd0, 2'd0, 1'b0, 5'b00000, 4'b0001, 4'b0001, 1'b1, 4'd5},  // 19 R5 lockout
    {3'd0, 2'd0, 1'b0, 5'b00000, 4'b0001, 4'b0001, 1'b1, 4'd5},  // 20 R5 lockout
    {3'd0, 2'd0, 1'b0, 5'b00000, 4'b0001, 4'b0001, 1'b1, 4'd5},  // 21 R5 lockout
    {3'd0, 2'd0, 1'b0, 5'b00011, 4'b0000, 4'b0001, 1'b0, 4'd5},  // 22 R5 pre started
    {3'd0, 2'd0, 1'b0, 5'b00011, 4'b0000, 4'b0001, 1'b0, 4'd9},  // 23 R9
    {3'd1, 2'd0, 1'b0, 5'b10011, 4'b0000, 4'b0001, 1'b0, 4'd3}   // 24 R3 idle again
  };

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [2:0] op, input logic [1:0] bank, input logic ap);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_bank  = bank;
    cmd_ap    = ap;
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    cmd_op = 3'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    do_reset();

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][23:21], VEC[i][20:19], VEC[i][18]);
      chk(int'(VEC[i][3:0]),
          32'({ok_act, ok_rd, ok_wr, ok_pre, ok_prea, row_open, ap_busy, cke_hold}),
          32'(VEC[i][17:4]), $sformatf("vector %0d", i));
    end
    apply(3'd0, 2'd0, 1'b0);
    // R11: the legal sequence leaves the error flag clear
    chk(11, 32'(proto_err), 32'd0, "no error after legal sequence");

    // R1: reset state
    do_reset();
    apply(3'd0, 2'd2, 1'b0);
    chk(1, 32'({ok_act, ok_rd, ok_wr, ok_pre, ok_prea, row_open, ap_busy, cke_hold, proto_err}),
        32'({5'b10011, 4'b0000, 4'b0000, 1'b0, 1'b0}), "reset state");

    // R12: an unused op code changes nothing
    apply(3'd7, 2'd2, 1'b0);
    apply(3'd0, 2'd2, 1'b0);
    chk(12, 32'({proto_err, row_open}), 32'd0, "op 7 ignored");

    // R11: read to an idle bank is illegal, sets the flag, leaves state alone
    apply(3'd2, 2'd2, 1'b0);
    chk(11, 32'(ok_rd), 32'd0, "read to idle bank flagged illegal");
    apply(3'd0, 2'd2, 1'b0);
    chk(11, 32'(proto_err), 32'd1, "error flag set");
    chk(11, 32'({ok_act, ok_rd, ok_wr, ok_pre, ok_prea, row_open}),
        32'({5'b10011, 4'b0000}), "bank state unchanged");

    // R3: activate spacing across banks; illegal activate has no effect
    apply(3'd1, 2'd2, 1'b0);
    apply(3'd1, 2'd3, 1'b0);
    chk(3, 32'(ok_act), 32'd0, "second activate inside rrd");
    apply(3'd1, 2'd3, 1'b0);
    chk(11, 32'(row_open), 32'b0100, "illegal activate opened nothing");
    chk(3, 32'(ok_act), 32'd1, "activate legal after rrd");

    // R4: precharge-all waits for the last bank's ras
    repeat (4) apply(3'd0, 2'd0, 1'b0);
    apply(3'd0, 2'd0, 1'b0);
    chk(4, 32'({ok_prea, row_open}), 32'({1'b0, 4'b1100}), "prea blocked by ras");
    apply(3'd5, 2'd0, 1'b0);
    chk(4, 32'(ok_prea), 32'd1, "prea legal once ras met");
    apply(3'd0, 2'd2, 1'b0);
    chk(4, 32'(row_open), 32'd0, "prea closed both banks");
    chk(3, 32'(ok_act), 32'd0, "activate blocked during rp");
    chk(11, 32'(proto_err), 32'd1, "error flag still set");

    // R11: reset clears the sticky flag
    do_reset();
    apply(3'd0, 2'd0, 1'b0);
    chk(11, 32'(proto_err), 32'd0, "reset clears error flag");

    finish_up();
  end
endmodule